// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the bit timing for an I2C master. One configuration word holds two fields. A prescale field divides the system clock into count steps. A gap field sets how many of those steps make up one SCL bit period. The period is a fixed base of twenty steps, plus eight steps for each gap unit, plus a compensation count. The compensation count is a build-time parameter that covers the bus rise time, the bus fall time and the internal delay, rounded up. Software works out the field values. The block only counts.

Each bit period starts with a low phase and ends with a high phase. The block drives an SCL level and raises three single-cycle strobes: one when SCL is pulled low, one when it is released high, and one in the middle of the high phase for sampling SDA. A stall input tells the block that SCL has not yet been seen high. While the stall input is set, the high-phase count waits. A new configuration word, or a drop of the run enable, takes effect only at a bit boundary.

Top module: `scl_rate_gen`

## Requirements
- R1: During and directly after reset, sclOut is 1, all three strobes are 0 and the generator is idle.
- R2: Configuration word bits [2:0] hold the prescale value `pre`, and bits [8:3] hold the gap value `gap` (0 to 63).
- R3: One count step lasts `pre + 1` clock cycles.
- R4: One bit period, with no stall, lasts P = 20 + 8·gap + COMP_TICKS count steps.
- R5: The low phase lasts ceil(P/2) steps. The high phase lasts floor(P/2) steps plus one clock for each clock edge at which the stall input is high during that phase.
- R6: fallStb is a one-cycle pulse in the first cycle that sclOut is 0. riseStb is a one-cycle pulse in the first cycle that sclOut is 1 again.
- R7: sampleStb pulses floor(floor(P/2)/2) steps after riseStb, plus the clock edges stalled in between, while sclOut is 1.
- R8: When enable is sampled high at a clock edge while the generator is idle, fallStb and sclOut = 0 appear in the next cycle.
- R9: If enable is low at the edge that ends a high phase, the generator goes idle with sclOut = 1 and no strobe. Dropping enable earlier does not shorten the current bit.
- R10: The stall input has no effect during the low phase or while idle.
- R11: The configuration word is sampled only at the edge that raises fallStb. Changes at any other time do not affect the current bit.
- R12: At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; checked at idle and at each bit boundary |
| stallIn | input | 1 | SCL not yet seen high; holds the high-phase count |
| ctrlWord | input | 9 | Configuration word: prescale in [2:0], gap in [8:3] |
| sclOut | output | 1 | SCL level to drive (0 = pull low) |
| fallStb | output | 1 | One-cycle strobe when SCL goes low |
| riseStb | output | 1 | One-cycle strobe when SCL is released high |
| sampleStb | output | 1 | One-cycle strobe in the middle of the high phase |

## Verification
Every output is registered. A fall strobe therefore appears one cycle after the edge at which enable or a bit boundary is seen. The rise strobe is due ceil(P/2)·(pre+1) edges after the fall strobe. The sample strobe and the next fall strobe are due floor(floor(P/2)/2)·(pre+1) and floor(P/2)·(pre+1) unstalled edges after the rise strobe. The bench samples 2 ns after each rising edge. It keeps its own countdown for each phase, computed from the configuration it saw on the fall-strobe edge, and compares all four outputs at every edge. The inputs change only on falling edges, so the values the bench reads at a sample are the values the design saw at that edge.

// File: rtl/scl_rate_pkg.sv
`timescale 1ns/1ps
package scl_rate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } sclState_t;

  // control -> datapath
  typedef struct packed {
    logic clear;      // hold both counters at zero
    logic count;      // advance the prescaler this cycle
    logic wrapPhase;  // phase ends at this edge: restart phase count
    logic loadCfg;    // capture the configuration word
  } ctlStrobes_t;

  // datapath -> control (register-only terms, no loop back)
  typedef struct packed {
    logic preWrap;     // prescaler at its last value
    logic atLowLast;   // phase count at last low step
    logic atHighLast;  // phase count at last high step
    logic atMidHigh;   // phase count at the step before mid-high
  } statusFlags_t;

endpackage

// File: rtl/scl_rate_datapath.sv
`timescale 1ns/1ps
module scl_rate_datapath
  import scl_rate_pkg::*;
#(
  parameter int PRE_W      = 3,
  parameter int GAP_W      = 6,
  parameter int BASE_TICKS = 20,
  parameter int GAP_STEP   = 8,
  parameter int COMP_TICKS = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PRE_W+GAP_W-1:0] ctrlWord,
  input  ctlStrobes_t            ctl,
  output statusFlags_t           st
);

  localparam int MAX_PER = BASE_TICKS + GAP_STEP * ((1 << GAP_W) - 1) + COMP_TICKS;
  localparam int PER_W   = $clog2(MAX_PER + 2);

  logic [PRE_W-1:0] cfgPre;
  logic [GAP_W-1:0] cfgGap;
  logic [PRE_W-1:0] preCnt;
  logic [PER_W-1:0] phaseCnt;
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] lowLen;
  logic [PER_W-1:0] highLen;
  logic [PER_W-1:0] midLen;
  logic             tick;

  // period arithmetic on the captured configuration
  always_comb begin
    period  = PER_W'(BASE_TICKS) + PER_W'(GAP_STEP) * PER_W'(cfgGap) + PER_W'(COMP_TICKS);
    lowLen  = (period + PER_W'(1)) >> 1;
    highLen = period >> 1;
    midLen  = highLen >> 1;
  end

  always_comb begin
    st.preWrap    = (preCnt == cfgPre);
    st.atLowLast  = (phaseCnt == lowLen - PER_W'(1));
    st.atHighLast = (phaseCnt == highLen - PER_W'(1));
    st.atMidHigh  = (phaseCnt == midLen - PER_W'(1));
  end

  assign tick = ctl.count && st.preWrap;

  // configuration capture: prescale low bits, gap above
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPre <= '0;
      cfgGap <= '0;
    end else if (ctl.loadCfg) begin
      cfgPre <= ctrlWord[PRE_W-1:0];
      cfgGap <= ctrlWord[PRE_W +: GAP_W];
    end
  end

  // prescaler: one count step per (cfgPre + 1) enabled clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctl.clear) begin
      preCnt <= '0;
    end else if (ctl.count) begin
      preCnt <= st.preWrap ? '0 : preCnt + PRE_W'(1);
    end
  end

  // phase step counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.clear || ctl.wrapPhase) begin
      phaseCnt <= '0;
    end else if (tick) begin
      phaseCnt <= phaseCnt + PER_W'(1);
    end
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.count && !ctl.clear) |=> ($stable(phaseCnt) && $stable(preCnt))); // R10
  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({cfgGap, cfgPre}) |-> (phaseCnt == '0 && preCnt == '0)); // R11
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.count |-> (phaseCnt <= lowLen - PER_W'(1))); // R5

endmodule

// File: rtl/scl_rate_ctrl.sv
`timescale 1ns/1ps
module scl_rate_ctrl
  import scl_rate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         stallIn,
  input  statusFlags_t st,
  output ctlStrobes_t  ctl,
  output logic         sclOut,
  output logic         fallStb,
  output logic         riseStb,
  output logic         sampleStb
);

  sclState_t state;
  sclState_t nextState;
  logic      phaseEnd;
  logic      midHit;

  always_comb begin
    nextState = state;
    ctl       = '0;
    phaseEnd  = 1'b0;
    midHit    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctl.clear = 1'b1;
        if (enable) begin
          ctl.loadCfg = 1'b1;
          nextState   = ST_LOW;
        end
      end
      ST_LOW: begin
        ctl.count = 1'b1;            // stall ignored while pulling low
        phaseEnd  = st.preWrap && st.atLowLast;
        if (phaseEnd) nextState = ST_HIGH;
      end
      ST_HIGH: begin
        ctl.count = !stallIn;        // wait for SCL to be seen high
        phaseEnd  = ctl.count && st.preWrap && st.atHighLast;
        midHit    = ctl.count && st.preWrap && st.atMidHigh;
        if (phaseEnd) begin
          if (enable) begin
            ctl.loadCfg = 1'b1;
            nextState   = ST_LOW;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    ctl.wrapPhase = phaseEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sclOut    <= 1'b1;
      fallStb   <= 1'b0;
      riseStb   <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      state     <= nextState;
      sclOut    <= (nextState != ST_LOW);
      fallStb   <= ctl.loadCfg;
      riseStb   <= (state == ST_LOW) && phaseEnd;
      sampleStb <= midHit;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fallStb, riseStb, sampleStb})); // R12
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> (!sclOut && $past(sclOut))); // R6
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> (sclOut && !$past(sclOut))); // R6
  AST_SAMPLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> sclOut); // R7

endmodule

// File: rtl/scl_rate_gen.sv
`timescale 1ns/1ps
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int PRE_W      = 3,
  parameter int GAP_W      = 6,
  parameter int BASE_TICKS = 20,
  parameter int GAP_STEP   = 8,
  parameter int COMP_TICKS = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   enable,
  input  logic                   stallIn,
  input  logic [PRE_W+GAP_W-1:0] ctrlWord,
  output logic                   sclOut,
  output logic                   fallStb,
  output logic                   riseStb,
  output logic                   sampleStb
);

  ctlStrobes_t  ctl;
  statusFlags_t st;

  scl_rate_datapath #(
    .PRE_W      (PRE_W),
    .GAP_W      (GAP_W),
    .BASE_TICKS (BASE_TICKS),
    .GAP_STEP   (GAP_STEP),
    .COMP_TICKS (COMP_TICKS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWord (ctrlWord),
    .ctl      (ctl),
    .st       (st)
  );

  scl_rate_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .stallIn   (stallIn),
    .st        (st),
    .ctl       (ctl),
    .sclOut    (sclOut),
    .fallStb   (fallStb),
    .riseStb   (riseStb),
    .sampleStb (sampleStb)
  );

endmodule

// File: tb/scl_rate_gen_tb_top.sv
`timescale 1ns/1ps
module scl_rate_gen_tb_top;

  localparam int COMP = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       stallIn = 1'b0;
  logic [8:0] ctrlWord = '0;
  logic       sclOut, fallStb, riseStb, sampleStb;

  int  checks = 0;
  int  fails = 0;
  int  fallSeen = 0;
  bit  stallNoise = 1'b0;
  bit  wordNoise = 1'b0;
  logic [8:0] fixedWord = '0;

  // bench model state: 0 idle, 1 low, 2 high
  int mState = 0;
  int loLeft = 0, hiLeft = 0, midLeft = 0, mDiv = 1;

  always #4 clk = ~clk;

  scl_rate_gen #(.COMP_TICKS(COMP)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .stallIn(stallIn),
    .ctrlWord(ctrlWord), .sclOut(sclOut), .fallStb(fallStb),
    .riseStb(riseStb), .sampleStb(sampleStb)
  );

  // R4: steps per period; R5: phase split; R7: mid-high point
  function automatic int perSteps(input int gap);
    return 20 + 8 * gap + COMP;
  endfunction
  function automatic int lowSteps(input int gap);
    return (perSteps(gap) + 1) / 2;
  endfunction
  function automatic int highSteps(input int gap);
    return perSteps(gap) / 2;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R2: word packing, prescale [2:0], gap [8:3]
  task automatic loadModel(input logic [8:0] w);
    mDiv   = int'(w[2:0]) + 1;
    loLeft = lowSteps(int'(w[8:3])) * mDiv;
    hiLeft = highSteps(int'(w[8:3])) * mDiv;
    midLeft = (highSteps(int'(w[8:3])) / 2) * mDiv;
    mState = 1;
    fallSeen++;
  endtask

  // monitor: 2 ns after each rising edge
  always @(posedge clk) begin
    bit expF, expR, expS;
    #2;
    expF = 0; expR = 0; expS = 0;
    if (!rstN) begin
      mState = 0;
      check("R1", "sclOut in reset", int'(sclOut), 1);
      check("R1", "strobes in reset", int'({fallStb, riseStb, sampleStb}), 0);
    end else begin
      case (mState)
        0: if (enable) begin expF = 1; loadModel(ctrlWord); end          // R8, R10 idle
        1: begin                                                          // R3 R5, R10 low
          loLeft--;
          if (loLeft == 0) begin expR = 1; mState = 2; end
        end
        default: begin
          if (!stallIn) begin                                             // R10 stall in high
            hiLeft--; midLeft--;
            if (midLeft == 0) expS = 1;                                   // R7
            if (hiLeft == 0) begin
              if (enable) begin expF = 1; loadModel(ctrlWord); end        // R11 sample point
              else mState = 0;                                            // R9
            end
          end
        end
      endcase
      check("R6 R8 R9 R11", "fallStb", int'(fallStb), int'(expF));
      check("R3 R4 R5 R6", "riseStb", int'(riseStb), int'(expR));
      check("R7 R10", "sampleStb", int'(sampleStb), int'(expS));
      check("R5 R6 R9", "sclOut", int'(sclOut), (mState == 1) ? 0 : 1);
      check("R12", "strobe count", $countones({fallStb, riseStb, sampleStb}) <= 1 ? 1 : 0, 1);
    end
  end

  // input drivers, falling edge only
  always @(negedge clk) begin
    stallIn <= stallNoise ? ($urandom % 4 == 0) : 1'b0;
    if (!wordNoise) ctrlWord <= fixedWord;
    else if ($urandom % 16 == 0) ctrlWord <= 9'($urandom);
  end

  task automatic waitFalls(input int n);
    int target = fallSeen + n;
    while (fallSeen < target) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (mState != 0) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1C2B));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R10: stall toggling while idle does nothing
    stallNoise = 1'b1;
    repeat (40) @(negedge clk);
    stallNoise = 1'b0;
    // shortest period: pre 0, gap 0
    fixedWord = {6'd0, 3'd0};
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitFalls(3);
    // R11: word changed mid-bit applies at next boundary; longest period
    fixedWord = {6'd63, 3'd7};
    waitFalls(2);
    fixedWord = {6'd63, 3'd0};
    waitFalls(2);
    // R10: stall noise in both phases
    fixedWord = {6'd3, 3'd2};
    stallNoise = 1'b1;
    waitFalls(4);
    // R9: drop enable mid-bit, bit completes then idles
    repeat (30) @(negedge clk);
    enable = 1'b0;
    waitIdle();
    repeat (20) @(negedge clk);
    enable = 1'b1;
    // random mix
    wordNoise = 1'b1;
    for (int i = 0; i < 40; i++) begin
      waitFalls(1);
      if ($urandom % 5 == 0) begin
        enable = 1'b0;
        waitIdle();
        repeat ($urandom % 5) @(negedge clk);
        enable = 1'b1;
      end
    end
    enable = 1'b0;
    waitIdle();
    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1-watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule